// File: doc/BRIEF.md
# Diagnostic FIFO Access Window

This block is a parameterized FIFO with 32-bit entries. A single register window gives a host direct access to the storage for test purposes. A direction input picks the side of the FIFO that the window reaches. While the direction is low, the window fills the FIFO. While it is high, the window drains it.

Window accesses only take effect when three mode inputs agree: the general diagnostic enable must be high, the fill-path enable must be low, and the output-side diagnostic enable must be high. The host first stores entries while the direction is low. It then raises the direction and makes one throwaway read, which primes an output latch. After that, it reads the entries back in the order they were written. When the three mode conditions stop agreeing, the pointers, the occupancy and the priming state are all cleared.

Top module: `diag_fifo_port`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: A write strobe has no effect unless `diag_on` is 1, `fill_on` is 0 and `outdiag_on` is 1 in the same cycle.
- R3: With access open and `dir_rd` low, each cycle with `wr_stb` high stores `wr_data` as one entry and advances the write pointer, so `empty` falls after the first write.
- R4: While `dir_rd` is high, write strobes store nothing.
- R5: While `dir_rd` is low, `rd_data` is 0.
- R6: The first read strobe after each rise of `dir_rd` is a priming read. During that read `rd_data` is 0, and the oldest entry moves into the output latch.
- R7: Each later read returns the latched entry during the strobe cycle, then loads the next entry. Entries come out in write order.
- R8: `full` is 1 when DEPTH entries are held. A write while full is dropped, and the stored entries are unchanged.
- R9: A read made when no entry remains in storage returns the latched value and loads 0. The read pointer does not move, so later reads return 0.
- R10: Any cycle in which access is not open clears both pointers, the occupancy and the priming state. `empty` becomes 1 on the next cycle.
- R11: After `dir_rd` falls and rises again, a new priming read returns 0 and replaces the latch with the next stored entry. The previously latched entry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| diag_on | input | 1 | General diagnostic enable (must be 1) |
| fill_on | input | 1 | Normal fill-path enable (must be 0) |
| outdiag_on | input | 1 | Output-side diagnostic enable (must be 1) |
| dir_rd | input | 1 | Window direction: 0 fills, 1 drains |
| wr_stb | input | 1 | Window write access |
| wr_data | input | WIDTH | Entry written by the host |
| rd_stb | input | 1 | Window read access |
| rd_data | output | WIDTH | Data returned for a read access |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entry held in storage |

## Verification
The bench targets several corner cases, and each one shows a distinct symptom when the design gets it wrong:
- **Priming read:** a design that skips priming shifts the whole readback by one entry.
- **Write while full:** a design that lets this write through corrupts the oldest entry, so the first value read back is wrong.
- **Read past the end:** a design that runs past the last entry returns stale storage instead of 0.
- **Mode exit:** a design that does not clear its pointers on leaving diagnostic mode keeps `empty` low after re-entry.
- **Direction toggle mid-drain:** a design that does not re-prime returns the discarded latch value.
- **Writes and reads in the wrong mode:** these must leave both the flags and the readback stream unchanged.

// File: rtl/dfp_pkg.sv
// Package: shared defaults and pointer arithmetic for the diagnostic FIFO window.
// Assumes depths of at least two entries.
package dfp_pkg;

    localparam int unsigned DFP_WIDTH = 32;
    localparam int unsigned DFP_DEPTH = 32;

    // Advance a pointer, wrapping at a depth that need not be a power of two.
    function automatic logic [15:0] ptr_step(input logic [15:0] ptr, input int unsigned depth);
        if (ptr == 16'(depth - 1)) begin
            return 16'd0;
        end
        return ptr + 16'd1;
    endfunction

endpackage

// File: rtl/dfp_access_gate.sv
// Module: dfp_access_gate
// Decides whether window accesses are open and which side they reach.
// It also detects the rise of the direction input.
// Assumes that the mode inputs are synchronous to clk.
module dfp_access_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic diag_on,
    input  logic fill_on,
    input  logic outdiag_on,
    input  logic dir_rd,
    input  logic wr_stb,
    input  logic rd_stb,
    output logic open_o,
    output logic wr_req_o,
    output logic rd_req_o,
    output logic rd_mode_o,
    output logic dir_rise_o
);

    logic dir_q;

    // Combine the three mode conditions and split the strobes by direction.
    always_comb begin
        open_o     = diag_on & ~fill_on & outdiag_on;
        rd_mode_o  = open_o & dir_rd;
        wr_req_o   = open_o & ~dir_rd & wr_stb;
        rd_req_o   = rd_mode_o & rd_stb;
        dir_rise_o = rd_mode_o & ~dir_q;
    end

    // Remember last cycle's direction so that a new drain phase can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
        end else begin
            dir_q <= dir_rd & open_o;
        end
    end

    a_r2_gate_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (diag_on && !fill_on && outdiag_on && !dir_rd));

    a_r4_no_write_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rd |-> !wr_req_o);

endmodule

// File: rtl/dfp_store.sv
// Module: dfp_store
// Entry storage with its write and read pointers and occupancy count.
// It presents the oldest held entry as a look-ahead head.
// Assumes that a write request and a read request never occur in the same cycle.
module dfp_store #(
    parameter int unsigned WIDTH = dfp_pkg::DFP_WIDTH,
    parameter int unsigned DEPTH = dfp_pkg::DFP_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             wr_req_i,
    input  logic             rd_req_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt;
    logic             push;
    logic             pop;

    // Qualify requests against the occupancy.
    always_comb begin
        full_o  = (cnt == FULL_CNT);
        empty_o = (cnt == '0);
        push    = wr_req_i & ~full_o;
        pop     = rd_req_i & ~empty_o;
        head_o  = mem[rd_ptr];
    end

    // Store an accepted entry; storage itself carries no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data_i;
        end
    end

    // Move pointers and count, clearing everything when access closes.
    always_ff @(posedge clk) begin
        if (!rst_n || !open_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= AW'(dfp_pkg::ptr_step(16'(wr_ptr), DEPTH));
            end
            if (pop) begin
                rd_ptr <= AW'(dfp_pkg::ptr_step(16'(rd_ptr), DEPTH));
            end
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && full_o && open_i) |=> (full_o && $stable(wr_ptr)));

    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && empty_o) |=> (empty_o && $stable(rd_ptr)));

    a_r3_write_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !full_o && open_i) |=> (cnt == $past(cnt) + 1'b1));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> (empty_o && wr_ptr == '0 && rd_ptr == '0));

    a_mutex_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req_i && rd_req_i));

endmodule

// File: rtl/dfp_out_latch.sv
// Module: dfp_out_latch
// Holds the output latch and the priming flag.
// The value returned for a read is the latched entry; the read then loads the next head.
// Assumes that head_i and empty_i come from the storage in the same cycle as rd_req_i.
module dfp_out_latch #(
    parameter int unsigned WIDTH = dfp_pkg::DFP_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             rd_mode_i,
    input  logic             rd_req_i,
    input  logic             dir_rise_i,
    input  logic [WIDTH-1:0] head_i,
    input  logic             empty_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic [WIDTH-1:0] latch_q;
    logic             primed_q;
    logic             show;

    // Return latched data only in drain mode once primed.
    always_comb begin
        show      = rd_mode_i & primed_q & ~dir_rise_i;
        rd_data_o = show ? latch_q : '0;
    end

    // Prime on the first read of a drain phase and refill the latch on every read.
    always_ff @(posedge clk) begin
        if (!rst_n || !open_i) begin
            latch_q  <= '0;
            primed_q <= 1'b0;
        end else if (rd_req_i) begin
            primed_q <= 1'b1;
            latch_q  <= empty_i ? '0 : head_i;
        end else if (dir_rise_i) begin
            primed_q <= 1'b0;
        end
    end

    a_r6_prime_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && open_i) |=> primed_q);

    a_r6_rise_unprimes: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rise_i && !rd_req_i) |=> !primed_q);

    a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req_i && open_i) |=> $stable(latch_q));

    a_r5_fill_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mode_i |-> (rd_data_o == '0));

endmodule

// File: rtl/diag_fifo_port.sv
// Module: diag_fifo_port (top)
// Diagnostic register window onto a FIFO.
// The host fills the FIFO while dir_rd is low. It then raises dir_rd, makes one priming read, and drains the entries in order.
// Assumes a single access per cycle and that the mode inputs are synchronous to clk.
module diag_fifo_port #(
    parameter int unsigned WIDTH = dfp_pkg::DFP_WIDTH,
    parameter int unsigned DEPTH = dfp_pkg::DFP_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             diag_on,
    input  logic             fill_on,
    input  logic             outdiag_on,
    input  logic             dir_rd,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_stb,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);

    logic             open_w;
    logic             wr_req_w;
    logic             rd_req_w;
    logic             rd_mode_w;
    logic             dir_rise_w;
    logic [WIDTH-1:0] head_w;

    dfp_access_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .diag_on    (diag_on),
        .fill_on    (fill_on),
        .outdiag_on (outdiag_on),
        .dir_rd     (dir_rd),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .open_o     (open_w),
        .wr_req_o   (wr_req_w),
        .rd_req_o   (rd_req_w),
        .rd_mode_o  (rd_mode_w),
        .dir_rise_o (dir_rise_w)
    );

    dfp_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (open_w),
        .wr_req_i  (wr_req_w),
        .rd_req_i  (rd_req_w),
        .wr_data_i (wr_data),
        .head_o    (head_w),
        .full_o    (full),
        .empty_o   (empty)
    );

    dfp_out_latch #(.WIDTH(WIDTH)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_i     (open_w),
        .rd_mode_i  (rd_mode_w),
        .rd_req_i   (rd_req_w),
        .dir_rise_i (dir_rise_w),
        .head_i     (head_w),
        .empty_i    (empty),
        .rd_data_o  (rd_data)
    );

    a_r1_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: tb/diag_fifo_port_test.sv
module diag_fifo_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 12;

    // Vector layout: {op[1:0], data[31:0], expected[31:0]}; op 0 write, 1 read+check, 2 dir high, 3 dir low
    localparam logic [65:0] VEC [NVEC] = '{
        {2'd0, 32'h1111_1111, 32'h0},        // R3 store
        {2'd0, 32'h2222_2222, 32'h0},        // R3 store
        {2'd0, 32'h3333_3333, 32'h0},        // R3 store
        {2'd1, 32'h0,         32'h0},        // R5 read while filling is zero
        {2'd2, 32'h0,         32'h0},        // enter drain
        {2'd0, 32'h4444_4444, 32'h0},        // R4 ignored write
        {2'd1, 32'h0,         32'h0},        // R6 priming read
        {2'd1, 32'h0,         32'h1111_1111},// R7 order
        {2'd1, 32'h0,         32'h2222_2222},// R7 order
        {2'd1, 32'h0,         32'h3333_3333},// R7 and R4 (no 4444 follows)
        {2'd1, 32'h0,         32'h0},        // R9 drained
        {2'd1, 32'h0,         32'h0}         // R9 drained
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        diag_on = 1'b1;
    logic        fill_on = 1'b0;
    logic        outdiag_on = 1'b1;
    logic        dir_rd = 1'b0;
    logic        wr_stb = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_stb = 1'b0;
    logic [31:0] rd_data;
    logic        full;
    logic        empty;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    diag_fifo_port #(.WIDTH(32), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .diag_on(diag_on), .fill_on(fill_on),
        .outdiag_on(outdiag_on), .dir_rd(dir_rd), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .full(full), .empty(empty)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic do_read(output logic [31:0] got);
        @(negedge clk); rd_stb = 1'b1; #1 got = rd_data;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic set_dir(input logic v);
        @(negedge clk); dir_rd = v;
        @(negedge clk);
    endtask

    task automatic reenter;
        @(negedge clk); diag_on = 1'b0; dir_rd = 1'b0;
        @(negedge clk); diag_on = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        check("R1 empty", 32'(empty), 32'd1);
        check("R1 full", 32'(full), 32'd0);
        check("R1 rd_data", rd_data, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][65:64])
                2'd0: do_write(VEC[i][63:32]);
                2'd1: begin
                    do_read(got);
                    check($sformatf("R5/R6/R7/R9 vector %0d", i), got, VEC[i][31:0]);
                end
                2'd2: set_dir(1'b1);
                default: set_dir(1'b0);
            endcase
        end
        check("R9 empty after drain", 32'(empty), 32'd1);

        // R2: closed window stores nothing
        reenter();
        fill_on = 1'b1; do_write(32'hBAD0_0001); fill_on = 1'b0;
        check("R2 fill_on blocks", 32'(empty), 32'd1);
        outdiag_on = 1'b0; do_write(32'hBAD0_0002); outdiag_on = 1'b1;
        @(negedge clk);
        check("R2 outdiag_on blocks", 32'(empty), 32'd1);

        // R3 and R8: fill to DEPTH, overflow dropped
        do_write(32'h0000_0100);
        check("R3 empty falls", 32'(empty), 32'd0);
        for (int k = 1; k < DEPTH; k++) do_write(32'h0000_0100 + 32'(k));
        check("R8 full", 32'(full), 32'd1);
        do_write(32'hDEAD_BEEF);
        check("R8 still full", 32'(full), 32'd1);
        set_dir(1'b1);
        do_read(got);
        check("R6 prime", got, 32'h0);
        for (int k = 0; k < DEPTH; k++) begin
            do_read(got);
            check("R8 readback", got, 32'h0000_0100 + 32'(k));
        end
        do_read(got);
        check("R9 past end", got, 32'h0);

        // R10: leaving diagnostic mode clears state
        reenter();
        do_write(32'hAAAA_0001); do_write(32'hAAAA_0002);
        reenter();
        check("R10 empty after exit", 32'(empty), 32'd1);
        set_dir(1'b1);
        do_read(got); do_read(got);
        check("R10 no stale data", got, 32'h0);

        // R11: re-prime after direction toggle
        reenter();
        do_write(32'hC000_000A); do_write(32'hC000_000B); do_write(32'hC000_000C);
        set_dir(1'b1);
        do_read(got);
        check("R11 first prime", got, 32'h0);
        do_read(got);
        check("R11 first entry", got, 32'hC000_000A);
        set_dir(1'b0);
        check("R5 zero in fill mode", rd_data, 32'h0);
        set_dir(1'b1);
        do_read(got);
        check("R11 second prime", got, 32'h0);
        do_read(got);
        check("R11 after re-prime", got, 32'hC000_000C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule